// File: doc/BRIEF.md
# Receive Buffer Credit Tracker

This block keeps count of the free receive buffers that software has handed to a DMA engine. It turns that count into a throttle signal toward the packet source. One tracking unit serves each pair of channels. The unit index is the channel number shifted right by one. Even channels receive and odd channels transmit, and only the receive channel of a pair feeds its unit.

Software adds credit by writing a buffer count to a unit's allocation register. The receive channel pulses a consume line each time it fills a buffer, and each pulse removes one credit. The throttle output uses two programmable watermarks with hysteresis between them. A force bit in the allocation register puts the unit into a quiet state, which software uses when it shuts the channel down. The usual setup is a low watermark of one third and a high watermark of two thirds of the receive descriptor count.

A global configuration register holds a controller enable, one enable bit per unit and a channel count field. All registers are reached through a simple single-cycle read/write port. Read data is combinational from the address.

Top module: `rx_credit_tracker`

## Requirements
- R1: The global register is at address 0x00. Unit u has its low watermark at 0x04+12u, its high watermark at 0x08+12u and its allocation register at 0x0C+12u. The watermarks read back zero-extended. Any other address reads zero.
- R2: A write to an allocation register with bit 31 clear adds bits 30:0 to the credit count, saturating at 2^CNT_W-1, and clears the unit's force state.
- R3: A consume pulse removes one credit, and the count never goes below zero. When a write and a consume land in the same cycle, the addition is applied first and the decrement second.
- R4: Throttle is set when the count falls below the low watermark and cleared when the count is at or above the high watermark. Between the two it keeps its previous value. When the watermarks are crossed (low above high), the below-low rule wins. Count and throttle both change on the clock edge that ends the causing cycle.
- R5: A write to an allocation register with bit 31 set clears the count and the throttle. The throttle then stays low until the next write to that register with bit 31 clear.
- R6: While global bit u+1 is clear, unit u holds a zero count and a low throttle, and allocation writes and consume pulses have no effect on its count. A global register write takes effect from the next cycle.
- R7: Reading an allocation register returns the credit count in bits CNT_W-1:0, the force state in bit 31, and zeros elsewhere.
- R8: The global register stores bit 0 (controller enable), bits NUM_UNITS:1 (unit enables) and bits 27:24 (channel count). All other bits are dropped on write and read as zero.
- R9: After reset all registers, counts and force states are zero and every throttle output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when set, read when clear |
| addr_i | input | ADDR_W (8) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| consume_i | input | NUM_UNITS (8) | Per-unit pulse: one buffer filled |
| throttle_o | output | NUM_UNITS (8) | Per-unit backpressure toward the packet source |

## Verification
A write or a consume pulse in cycle t shows up in the count and the throttle after the rising edge that ends cycle t. Reads are combinational and reflect the registers in the same cycle. A global register write changes unit behaviour only from cycle t+1. The bench drives every stimulus on the falling edge and advances its behavioural model on the rising edge. It compares the throttle vector at the next falling edge, and it samples read data 1 ns after the address is presented. Because of this, every comparison falls exactly one register stage after its cause, with no race against the edge.

// File: rtl/rx_credit_pkg.sv
`timescale 1ns/1ps
package rx_credit_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned UNIT_BASE   = 4;
  localparam int unsigned UNIT_STRIDE = 12;
  localparam int unsigned FORCE_BIT   = 31;
  localparam int unsigned CHCNT_LSB   = 24;
  localparam int unsigned CHCNT_W     = 4;

  typedef enum logic [1:0] {
    OFS_LO    = 2'd0,
    OFS_HI    = 2'd1,
    OFS_ALLOC = 2'd2
  } unit_ofs_e;

  function automatic int unsigned unit_addr(int unsigned u, unit_ofs_e k);
    return UNIT_BASE + UNIT_STRIDE * u + 4 * int'(k);
  endfunction
endpackage

// File: rtl/rcf_regdec.sv
`timescale 1ns/1ps
module rcf_regdec
  import rx_credit_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 cfg_hit_o,
  output logic [NUM_UNITS-1:0] lo_hit_o,
  output logic [NUM_UNITS-1:0] hi_hit_o,
  output logic [NUM_UNITS-1:0] alloc_hit_o,
  output logic                 cfg_we_o,
  output logic [NUM_UNITS-1:0] lo_we_o,
  output logic [NUM_UNITS-1:0] hi_we_o,
  output logic [NUM_UNITS-1:0] alloc_we_o
);
  logic wr;
  assign wr        = req_i & we_i;
  assign cfg_hit_o = (addr_i == '0);
  assign cfg_we_o  = wr & cfg_hit_o;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam logic [ADDR_W-1:0] LoA = ADDR_W'(unit_addr(u, OFS_LO));
    localparam logic [ADDR_W-1:0] HiA = ADDR_W'(unit_addr(u, OFS_HI));
    localparam logic [ADDR_W-1:0] AlA = ADDR_W'(unit_addr(u, OFS_ALLOC));
    assign lo_hit_o[u]    = (addr_i == LoA);
    assign hi_hit_o[u]    = (addr_i == HiA);
    assign alloc_hit_o[u] = (addr_i == AlA);
    assign lo_we_o[u]     = wr & lo_hit_o[u];
    assign hi_we_o[u]     = wr & hi_hit_o[u];
    assign alloc_we_o[u]  = wr & alloc_hit_o[u];
  end
endmodule

// File: rtl/rcf_cfg.sv
`timescale 1ns/1ps
module rcf_cfg
  import rx_credit_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cfg_o
);
  localparam logic [DATA_W-1:0] EnMask  = DATA_W'((64'd1 << (NUM_UNITS + 1)) - 64'd1);
  localparam logic [DATA_W-1:0] CntMask = DATA_W'(((64'd1 << CHCNT_W) - 64'd1) << CHCNT_LSB);
  localparam logic [DATA_W-1:0] WrMask  = EnMask | CntMask;

  logic [DATA_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i & WrMask;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/rcf_unit.sv
`timescale 1ns/1ps
module rcf_unit
  import rx_credit_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic              alloc_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              consume_i,
  output logic [CNT_W-1:0]  lo_o,
  output logic [CNT_W-1:0]  hi_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              force_o,
  output logic              throttle_o
);
  localparam logic [DATA_W-1:0] MaxCnt32 = DATA_W'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0]  lo_q, hi_q, cnt_q, cnt_d;
  logic              force_q, force_d, thr_q, thr_d;
  logic [DATA_W-1:0] sum;

  always_comb begin
    sum     = DATA_W'(cnt_q) + {1'b0, wdata_i[DATA_W-2:0]};
    cnt_d   = cnt_q;
    force_d = force_q;
    if (alloc_we_i) begin
      if (wdata_i[FORCE_BIT]) begin
        force_d = 1'b1;
        cnt_d   = '0;
      end else begin
        force_d = 1'b0;
        cnt_d   = (sum > MaxCnt32) ? MaxCnt32[CNT_W-1:0] : sum[CNT_W-1:0];
      end
    end
    if (consume_i && (cnt_d != '0)) cnt_d = cnt_d - 1'b1;
    if (!en_i) cnt_d = '0;

    // hysteresis on the value being registered; below-low wins
    thr_d = thr_q;
    if (!en_i || force_d)  thr_d = 1'b0;
    else if (cnt_d < lo_q) thr_d = 1'b1;
    else if (cnt_d >= hi_q) thr_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      cnt_q   <= '0;
      force_q <= 1'b0;
      thr_q   <= 1'b0;
    end else begin
      if (lo_we_i) lo_q <= wdata_i[CNT_W-1:0];
      if (hi_we_i) hi_q <= wdata_i[CNT_W-1:0];
      cnt_q   <= cnt_d;
      force_q <= force_d;
      thr_q   <= thr_d;
    end
  end

  assign lo_o       = lo_q;
  assign hi_o       = hi_q;
  assign cnt_o      = cnt_q;
  assign force_o    = force_q;
  assign throttle_o = thr_q;
endmodule

// File: rtl/rx_credit_tracker.sv
`timescale 1ns/1ps
module rx_credit_tracker
  import rx_credit_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_UNITS-1:0] consume_i,
  output logic [NUM_UNITS-1:0] throttle_o
);
  logic                 cfg_hit, cfg_we;
  logic [NUM_UNITS-1:0] lo_hit, hi_hit, alloc_hit;
  logic [NUM_UNITS-1:0] lo_we, hi_we, alloc_we;
  logic [DATA_W-1:0]    cfg_q;
  logic [NUM_UNITS-1:0] unit_en;
  logic [NUM_UNITS-1:0] force_w;
  logic [NUM_UNITS-1:0][CNT_W-1:0] lo_w, hi_w, cnt_w;

  rcf_regdec #(.NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W)) u_dec (
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .cfg_hit_o   (cfg_hit),
    .lo_hit_o    (lo_hit),
    .hi_hit_o    (hi_hit),
    .alloc_hit_o (alloc_hit),
    .cfg_we_o    (cfg_we),
    .lo_we_o     (lo_we),
    .hi_we_o     (hi_we),
    .alloc_we_o  (alloc_we)
  );

  rcf_cfg #(.NUM_UNITS(NUM_UNITS)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we),
    .wdata_i (wdata_i),
    .cfg_o   (cfg_q)
  );

  assign unit_en = cfg_q[NUM_UNITS:1];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    rcf_unit #(.CNT_W(CNT_W)) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (unit_en[u]),
      .lo_we_i    (lo_we[u]),
      .hi_we_i    (hi_we[u]),
      .alloc_we_i (alloc_we[u]),
      .wdata_i    (wdata_i),
      .consume_i  (consume_i[u]),
      .lo_o       (lo_w[u]),
      .hi_o       (hi_w[u]),
      .cnt_o      (cnt_w[u]),
      .force_o    (force_w[u]),
      .throttle_o (throttle_o[u])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (cfg_hit) rdata_o = cfg_q;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (lo_hit[u])    rdata_o = DATA_W'(lo_w[u]);
      if (hi_hit[u])    rdata_o = DATA_W'(hi_w[u]);
      if (alloc_hit[u]) rdata_o = DATA_W'(cnt_w[u]) | (DATA_W'(force_w[u]) << FORCE_BIT);
    end
  end
endmodule

// File: rtl/rx_credit_tracker_chk.sv
`timescale 1ns/1ps
module rx_credit_tracker_chk #(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned CNT_W     = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_UNITS-1:0]            unit_en,
  input logic [NUM_UNITS-1:0]            alloc_we,
  input logic [NUM_UNITS-1:0]            consume_i,
  input logic [31:0]                     wdata_i,
  input logic [NUM_UNITS-1:0]            throttle_o,
  input logic [NUM_UNITS-1:0]            force_w,
  input logic [NUM_UNITS-1:0][CNT_W-1:0] cnt_w,
  input logic [NUM_UNITS-1:0][CNT_W-1:0] lo_w,
  input logic [NUM_UNITS-1:0][CNT_W-1:0] hi_w
);
  localparam logic [31:0] MaxC = 32'((64'd1 << CNT_W) - 64'd1);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
    // R6
    a_r6_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !unit_en[u] |=> (cnt_w[u] == '0) && !throttle_o[u]);
    // R3
    a_r3_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
      consume_i[u] && (cnt_w[u] == '0) && !alloc_we[u] |=> cnt_w[u] == '0);
    a_r3_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_en[u] && consume_i[u] && !alloc_we[u] && (cnt_w[u] != '0)
      |=> cnt_w[u] == $past(cnt_w[u]) - 1'b1);
    // R2
    a_r2_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_en[u] && alloc_we[u] && !wdata_i[31] && !consume_i[u] &&
      (32'(cnt_w[u]) + {1'b0, wdata_i[30:0]} <= MaxC)
      |=> 32'(cnt_w[u]) == 32'($past(cnt_w[u])) + {1'b0, $past(wdata_i[30:0])});
    // R5
    a_r5_force_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alloc_we[u] && wdata_i[31] |=> (cnt_w[u] == '0) && !throttle_o[u] && force_w[u]);
    // R4
    a_r4_rise_below_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(throttle_o[u]) |-> cnt_w[u] < $past(lo_w[u]));
    a_r4_fall_at_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(throttle_o[u]) |-> ($past(!unit_en[u]) || force_w[u] ||
                                (cnt_w[u] >= $past(hi_w[u]))));
  end
endmodule

bind rx_credit_tracker rx_credit_tracker_chk #(.NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .unit_en    (unit_en),
  .alloc_we   (alloc_we),
  .consume_i  (consume_i),
  .wdata_i    (wdata_i),
  .throttle_o (throttle_o),
  .force_w    (force_w),
  .cnt_w      (cnt_w),
  .lo_w       (lo_w),
  .hi_w       (hi_w)
);

// File: tb/rx_credit_tracker_tb.sv
`timescale 1ns/1ps
module rx_credit_tracker_tb;
  localparam int NU   = 8;
  localparam int CW   = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NU-1:0] consume_i = '0;
  logic [NU-1:0] throttle_o;

  int checks = 0, fails = 0;

  // behavioural reference state
  logic [31:0] m_cfg = '0;
  longint m_cnt [NU];
  int     m_lo  [NU];
  int     m_hi  [NU];
  bit     m_frc [NU];
  bit     m_thr [NU];

  rx_credit_tracker #(.NUM_UNITS(NU), .CNT_W(CW), .ADDR_W(8)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .consume_i(consume_i), .throttle_o(throttle_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic int a_lo(int u);    return 4 + 12*u;  endfunction
  function automatic int a_hi(int u);    return 8 + 12*u;  endfunction
  function automatic int a_alloc(int u); return 12 + 12*u; endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 8'h00) r = m_cfg;
    for (int u = 0; u < NU; u++) begin
      if (int'(a) == a_lo(u))    r = 32'(m_lo[u]);
      if (int'(a) == a_hi(u))    r = 32'(m_hi[u]);
      if (int'(a) == a_alloc(u)) r = 32'(m_cnt[u]) | (32'(m_frc[u]) << 31);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  initial for (int u = 0; u < NU; u++) begin
    m_cnt[u] = 0; m_lo[u] = 0; m_hi[u] = 0; m_frc[u] = 0; m_thr[u] = 0;
  end

  // reference model: advances on each rising edge from the inputs of that cycle
  always @(posedge clk_i) if (rst_ni) begin
    longint c;
    bit     f, t, en;
    for (int u = 0; u < NU; u++) begin
      en = m_cfg[u+1];
      c  = m_cnt[u];
      f  = m_frc[u];
      t  = m_thr[u];
      if (req_i && we_i && int'(addr_i) == a_alloc(u)) begin
        if (wdata_i[31]) begin f = 1; c = 0; end
        else begin
          f = 0;
          c = c + longint'(wdata_i[30:0]);
          if (c > MAXC) c = MAXC;
        end
      end
      if (consume_i[u] && c > 0) c = c - 1;
      if (!en) c = 0;
      if (!en || f)            t = 0;
      else if (c < m_lo[u])    t = 1;
      else if (c >= m_hi[u])   t = 0;
      m_cnt[u] = c; m_frc[u] = f; m_thr[u] = t;
      if (req_i && we_i && int'(addr_i) == a_lo(u)) m_lo[u] = int'(wdata_i[CW-1:0]);
      if (req_i && we_i && int'(addr_i) == a_hi(u)) m_hi[u] = int'(wdata_i[CW-1:0]);
    end
    if (req_i && we_i && addr_i == 8'h00)
      m_cfg = wdata_i & (32'h0F00_0000 | 32'((1 << (NU+1)) - 1));
  end

  // throttle vector compared every cycle (R4, R5, R6, R9)
  always @(negedge clk_i) if (rst_ni) begin
    logic [NU-1:0] e;
    for (int u = 0; u < NU; u++) e[u] = m_thr[u];
    check("R4 throttle vector", 32'(throttle_o), 32'(e));
  end

  task automatic wr(int a, logic [31:0] d, logic [NU-1:0] cons = '0);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 8'(a); wdata_i = d; consume_i = cons;
    @(negedge clk_i);
    req_i = 0; we_i = 0; consume_i = '0;
  endtask

  task automatic rd(string tag, int a);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = 8'(a);
    #1;
    check(tag, rdata_o, m_read(8'(a)));
    req_i = 0;
  endtask

  task automatic pulse(logic [NU-1:0] v);
    @(negedge clk_i); consume_i = v;
    @(negedge clk_i); consume_i = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R9 reset state
    rd("R9 cfg after reset", 0);
    rd("R9 alloc0 after reset", a_alloc(0));
    check("R9 throttle after reset", 32'(throttle_o), 32'h0);
    // R8 writable fields
    wr(0, 32'hFFFF_FFFF);
    rd("R8 cfg mask", 0);
    check("R8 cfg literal", rdata_o, 32'h0F00_01FF);
    wr(0, 32'h0300_000B);          // ctrl en, unit0 en, unit2 en, count 3
    rd("R8 cfg readback", 0);
    // R1 map
    wr(a_lo(0), 2); wr(a_hi(0), 4);
    rd("R1 lo0", a_lo(0)); rd("R1 hi0", a_hi(0));
    check("R1 hi0 literal", rdata_o, 32'd4);
    wr(a_lo(2), 32'hFFFF_FF05); wr(a_hi(2), 3);
    rd("R1 lo2 truncated", a_lo(2)); rd("R1 hi2", a_hi(2));
    rd("R1 unmapped 02", 8'h02); rd("R1 unmapped 05", 8'h05); rd("R1 unmapped past end", 8'h64);
    // R4 count 0 below low -> throttle; R2 adds
    wr(a_alloc(0), 1); rd("R2 alloc 1", a_alloc(0));
    check("R4 asserted below low", 32'(throttle_o[0]), 32'd1);
    wr(a_alloc(0), 2); rd("R2 alloc to 3", a_alloc(0));
    check("R4 held between", 32'(throttle_o[0]), 32'd1);
    wr(a_alloc(0), 1); rd("R7 count 4", a_alloc(0));
    check("R4 released at high", 32'(throttle_o[0]), 32'd0);
    // R3 decrements
    pulse(8'h01); pulse(8'h01); rd("R3 after two consumes", a_alloc(0));
    check("R4 held low between", 32'(throttle_o[0]), 32'd0);
    pulse(8'h01); check("R4 reasserted", 32'(throttle_o[0]), 32'd1);
    pulse(8'h01); pulse(8'h01); pulse(8'h01); rd("R3 floor at zero", a_alloc(0));
    wr(a_alloc(0), 3, 8'h01); rd("R3 add then consume", a_alloc(0));
    check("R3 literal 2", rdata_o, 32'd2);
    // R5 force
    wr(a_alloc(0), 32'h8000_0000); rd("R5 force readback", a_alloc(0));
    check("R7 force bit literal", rdata_o, 32'h8000_0000);
    pulse(8'h01); repeat (3) @(negedge clk_i);
    check("R5 throttle held low", 32'(throttle_o[0]), 32'd0);
    wr(a_alloc(0), 5); rd("R5 force cleared by add", a_alloc(0));
    // R2 saturation
    wr(a_alloc(0), 300); rd("R2 saturate", a_alloc(0));
    wr(a_alloc(0), 32'h7FFF_FFFF); rd("R2 saturate large", a_alloc(0));
    check("R2 literal max", rdata_o, 32'(MAXC));
    // R6 disable unit 0
    wr(0, 32'h0300_0009);
    @(negedge clk_i); rd("R6 disabled count zero", a_alloc(0));
    wr(a_alloc(0), 3); pulse(8'h01); rd("R6 alloc ignored", a_alloc(0));
    check("R6 throttle low", 32'(throttle_o[0]), 32'd0);
    wr(0, 32'h0300_000B);
    // R4 crossed watermarks on unit 2: lo=5 hi=3
    wr(a_alloc(2), 4); rd("R4 crossed count", a_alloc(2));
    check("R4 crossed below-low wins", 32'(throttle_o[2]), 32'd1);
    wr(a_alloc(2), 2);
    check("R4 crossed release", 32'(throttle_o[2]), 32'd0);
    // mixed traffic on all units
    wr(0, 32'h0F00_01FF);
    for (int u = 0; u < NU; u++) begin wr(a_lo(u), 2); wr(a_hi(u), 5); end
    for (int i = 0; i < 1500; i++) begin
      int r, u;
      @(negedge clk_i);
      r = int'($urandom_range(0, 99));
      u = int'($urandom_range(0, NU-1));
      consume_i = NU'($urandom);
      req_i = 0; we_i = 0;
      if (r < 30) begin
        req_i = 1; we_i = 1; addr_i = 8'(a_alloc(u)); wdata_i = 32'($urandom_range(0, 3));
      end else if (r < 32) begin
        req_i = 1; we_i = 1; addr_i = 8'(a_alloc(u)); wdata_i = 32'h8000_0000;
      end else if (r < 34) begin
        req_i = 1; we_i = 1; addr_i = 8'h00;
        wdata_i = 32'h0F00_0001 | ({$urandom} & 32'h1FE) | 32'h1FE * (r & 1);
      end else if (r < 60) begin
        addr_i = 8'(a_alloc(u)); req_i = 1;
        #1 check("R7 mixed count", rdata_o, m_read(addr_i));
      end
    end
    @(negedge clk_i);
    req_i = 0; we_i = 0; consume_i = '0;
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule